// File: doc/BRIEF.md
# Card Block Stream Bridge

This block sits between the block data path of an SD/eMMC host controller and a pair of AXI4-Stream ports. The controller selects streaming instead of a memory transfer by loading its DMA address register with all ones. The direction of the card command in progress then decides which way the data moves.

For a write to the card, words from the input stream carry no TLAST. They are counted into 512-byte blocks by length alone. A new block starts only once the card side reports room for it. For a read from the card, each received word goes into a one-entry output register, and the final word of each block is marked with TLAST.

One stream transfer may span many consecutive blocks. A running block count tells the controller when to end a multi-block command. After a transfer error, a soft reset puts the stream back on a block boundary. It clears the beat position, the block count and any word held in the output register.

Top module: `sdstr_bridge`

## Requirements
- R1: Streaming is enabled only while `dma_addr_i` equals all ones and `cmd_active_i` is high. Otherwise `s_tready_o`, `wr_valid_o`, `wr_last_o` and `rd_ready_o` stay low.
- R2: With streaming enabled, `cmd_write_i`=1 selects the write path (stream to card) and holds `rd_ready_o` low. `cmd_write_i`=0 selects the read path (card to stream) and holds `s_tready_o` and `wr_valid_o` low.
- R3: On the write path, `wr_data_o` equals `s_tdata_i`. `wr_valid_o` equals `s_tvalid_i` and `s_tready_o` equals `wr_ready_i`, both gated by R5.
- R4: The input has no TLAST. Accepted write words are counted by length, and `wr_last_o` is high while the next word to be accepted is word 127 of its block (words numbered 0 to 127).
- R5: At word 0 of a block, the write path accepts nothing (`s_tready_o`=0, `wr_valid_o`=0) while `card_blk_rdy_i` is low. Inside a block, `card_blk_rdy_i` has no effect.
- R6: On the read path, `rd_ready_o` is high when the output register is empty or is being emptied in the same cycle. An accepted card word appears on `m_tdata_o` with `m_tvalid_o`=1 on the next cycle.
- R7: `m_tlast_o` is 1 exactly on output word 127 of each 128-word block.
- R8: While `m_tvalid_o`=1 and `m_tready_i`=0, the output word, its TLAST flag and its valid flag hold on the next cycle, unless a soft reset occurs.
- R9: `blk_count_o` increases by one for each write block whose word 127 is accepted. It also increases by one for each output word taken with `m_tlast_o`=1. It is otherwise stable and wraps at its width.
- R10: `soft_rst_i` clears the word position, `blk_count_o` and the output register on the next cycle.
- R11: After `rst_ni` is released, `m_tvalid_o`=0, `blk_count_o`=0 and the word position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous realignment clear |
| dma_addr_i | input | 32 | DMA address register; all ones selects streaming |
| cmd_active_i | input | 1 | A data command is in progress |
| cmd_write_i | input | 1 | 1: write to card, 0: read from card |
| s_tdata_i | input | 32 | Input stream data |
| s_tvalid_i | input | 1 | Input stream valid |
| s_tready_o | output | 1 | Input stream ready |
| card_blk_rdy_i | input | 1 | Card side can take a new block |
| wr_data_o | output | 32 | Word to card |
| wr_valid_o | output | 1 | Word to card valid |
| wr_last_o | output | 1 | Word to card ends a block |
| wr_ready_i | input | 1 | Card takes the word |
| rd_data_i | input | 32 | Word from card |
| rd_valid_i | input | 1 | Word from card valid |
| rd_ready_o | output | 1 | Bridge takes the card word |
| m_tdata_o | output | 32 | Output stream data |
| m_tvalid_o | output | 1 | Output stream valid |
| m_tlast_o | output | 1 | Output stream end of block |
| m_tready_i | input | 1 | Output stream ready |
| blk_count_o | output | 16 | Completed blocks since reset |

## Verification
A wrong word position misplaces `wr_last_o` or `m_tlast_o` within one block, at most 128 accepted words. It also shifts when the `card_blk_rdy_i` gate applies, and that shows in the first cycle that gate matters. A corrupted output register shows as `m_tdata_o` or `m_tvalid_o` changing under backpressure in the next cycle. A wrong block count differs at `blk_count_o` in the cycle after the block ends. The reference model compares every output on every clock, through long write and read runs with random stalls, deselection by address, and a soft reset in the middle of a block.

// File: rtl/sdstr_pkg.sv
package sdstr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_SINK = 2'd1,  // stream -> card
    MODE_SRC  = 2'd2   // card -> stream
  } sdstr_mode_e;
endpackage

// File: rtl/sdstr_mode_dec.sv
module sdstr_mode_dec
  import sdstr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              cmd_active_i,
  input  logic              cmd_write_i,
  output sdstr_mode_e       mode_o
);
  logic sel;
  assign sel = (dma_addr_i == {ADDR_W{1'b1}}) && cmd_active_i;

  always_comb begin
    mode_o = MODE_IDLE;
    if (sel) mode_o = cmd_write_i ? MODE_SINK : MODE_SRC;
  end
endmodule

// File: rtl/sdstr_beat_ctr.sv
module sdstr_beat_ctr #(
  parameter int unsigned BEATS  = 128,
  localparam int unsigned BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              at_last_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  assign at_last_o = (beat_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        beat_o <= '0;
    else if (clr_i)     beat_o <= '0;
    else if (adv_i)     beat_o <= at_last_o ? '0 : beat_o + 1'b1;
  end
endmodule

// File: rtl/sdstr_out_reg.sv
module sdstr_out_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              free_o
);
  assign free_o = !valid_o || take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (ld_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      last_o  <= last_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdstr_bridge.sv
module sdstr_bridge
  import sdstr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 512,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned BEATS    = BLK_BYTES / (DATA_W / 8),
  localparam int unsigned BEAT_W   = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              cmd_active_i,
  input  logic              cmd_write_i,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic              card_blk_rdy_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              wr_last_o,
  input  logic              wr_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tvalid_o,
  output logic              m_tlast_o,
  input  logic              m_tready_i,
  output logic [CNT_W-1:0]  blk_count_o
);
  sdstr_mode_e       mode;
  logic              wr_en, rd_en;
  logic [BEAT_W-1:0] beat;
  logic              at_last, blk_ok;
  logic              wr_fire, rd_fire, m_fire, out_free;

  sdstr_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .dma_addr_i  (dma_addr_i),
    .cmd_active_i(cmd_active_i),
    .cmd_write_i (cmd_write_i),
    .mode_o      (mode)
  );

  assign wr_en = (mode == MODE_SINK);
  assign rd_en = (mode == MODE_SRC);

  // a fresh block needs room on the card side; mid-block it is committed
  assign blk_ok     = (beat != '0) || card_blk_rdy_i;
  assign s_tready_o = wr_en && wr_ready_i && blk_ok;
  assign wr_valid_o = wr_en && s_tvalid_i && blk_ok;
  assign wr_data_o  = s_tdata_i;
  assign wr_last_o  = wr_en && at_last;
  assign wr_fire    = s_tvalid_i && s_tready_o;

  assign rd_ready_o = rd_en && out_free;
  assign rd_fire    = rd_valid_i && rd_ready_o;
  assign m_fire     = m_tvalid_o && m_tready_i;

  sdstr_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .adv_i    (wr_fire || rd_fire),
    .beat_o   (beat),
    .at_last_o(at_last)
  );

  sdstr_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .ld_i   (rd_fire),
    .data_i (rd_data_i),
    .last_i (at_last),
    .take_i (m_tready_i),
    .valid_o(m_tvalid_o),
    .data_o (m_tdata_o),
    .last_o (m_tlast_o),
    .free_o (out_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         blk_count_o <= '0;
    else if (soft_rst_i) blk_count_o <= '0;
    else                 blk_count_o <= blk_count_o
                                        + CNT_W'(wr_fire && at_last)
                                        + CNT_W'(m_fire && m_tlast_o);
  end
endmodule

// File: rtl/sdstr_bridge_chk.sv
module sdstr_bridge_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic [ADDR_W-1:0] dma_addr_i,
  input logic              cmd_active_i,
  input logic              s_tvalid_i,
  input logic              s_tready_o,
  input logic              wr_valid_o,
  input logic              wr_last_o,
  input logic              rd_ready_o,
  input logic [DATA_W-1:0] m_tdata_o,
  input logic              m_tvalid_o,
  input logic              m_tlast_o,
  input logic              m_tready_i,
  input logic [CNT_W-1:0]  blk_count_o
);
  // R1
  no_sel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_addr_i != {ADDR_W{1'b1}} || !cmd_active_i) |->
      (!s_tready_o && !wr_valid_o && !wr_last_o && !rd_ready_o));

  // R2
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ready_o && (s_tready_o || wr_valid_o)));

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i && !soft_rst_i) |=>
      (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));

  // R10
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!m_tvalid_o && blk_count_o == '0));

  // R9
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && !(s_tvalid_i && s_tready_o && wr_last_o)
     && !(m_tvalid_o && m_tready_i && m_tlast_o)) |=> $stable(blk_count_o));
endmodule

bind sdstr_bridge sdstr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .dma_addr_i  (dma_addr_i),
  .cmd_active_i(cmd_active_i),
  .s_tvalid_i  (s_tvalid_i),
  .s_tready_o  (s_tready_o),
  .wr_valid_o  (wr_valid_o),
  .wr_last_o   (wr_last_o),
  .rd_ready_o  (rd_ready_o),
  .m_tdata_o   (m_tdata_o),
  .m_tvalid_o  (m_tvalid_o),
  .m_tlast_o   (m_tlast_o),
  .m_tready_i  (m_tready_i),
  .blk_count_o (blk_count_o)
);

// File: tb/tb_sdstr_bridge.sv
module tb_sdstr_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [31:0] dma_addr_i = '0;
  logic        cmd_active_i = 1'b0, cmd_write_i = 1'b0;
  logic [31:0] s_tdata_i = '0;
  logic        s_tvalid_i = 1'b0, card_blk_rdy_i = 1'b0, wr_ready_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_valid_i = 1'b0, m_tready_i = 1'b0;
  logic        s_tready_o, wr_valid_o, wr_last_o, rd_ready_o;
  logic        m_tvalid_o, m_tlast_o;
  logic [31:0] wr_data_o, m_tdata_o;
  logic [15:0] blk_count_o;

  sdstr_bridge dut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  int m_beat = 0, m_cnt = 0;
  bit m_v = 0, m_l = 0;
  logic [31:0] m_d = '0;
  int wr_lasts = 0, rd_lasts = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit sel, input bit act, input bit wr, input int pv,
                       input int pr, input int pb, input int pm, input bit srst);
    bit en_w, en_r, ok_blk, e_tready, e_wvalid, e_wlast, e_rready, wf, rf, mf;
    @(negedge clk_i);
    dma_addr_i     = sel ? 32'hFFFF_FFFF : ($urandom | 32'h1) & 32'hFFFF_FFFE;
    cmd_active_i   = act;
    cmd_write_i    = wr;
    s_tdata_i      = $urandom;
    s_tvalid_i     = ($urandom % 100) < pv;
    wr_ready_i     = ($urandom % 100) < pr;
    card_blk_rdy_i = ($urandom % 100) < pb;
    rd_data_i      = $urandom;
    rd_valid_i     = ($urandom % 100) < pv;
    m_tready_i     = ($urandom % 100) < pm;
    soft_rst_i     = srst;
    #1;
    en_w = sel && act && wr;
    en_r = sel && act && !wr;
    ok_blk   = (m_beat != 0) || card_blk_rdy_i;
    e_tready = en_w && wr_ready_i && ok_blk;
    e_wvalid = en_w && s_tvalid_i && ok_blk;
    e_wlast  = en_w && (m_beat == 127);
    e_rready = en_r && (!m_v || m_tready_i);
    chk(s_tready_o == e_tready, (en_w || !sel) ? "R5" : "R2", "s_tready", s_tready_o, e_tready);
    chk(wr_valid_o == e_wvalid, sel ? "R3" : "R1", "wr_valid", wr_valid_o, e_wvalid);
    chk(wr_last_o == e_wlast, "R4", "wr_last", wr_last_o, e_wlast);
    chk(rd_ready_o == e_rready, en_r ? "R6" : "R2", "rd_ready", rd_ready_o, e_rready);
    if (en_w) chk(wr_data_o == s_tdata_i, "R3", "wr_data", wr_data_o, s_tdata_i);
    chk(m_tvalid_o == m_v, "R8", "m_tvalid", m_tvalid_o, m_v);
    if (m_v) begin
      chk(m_tdata_o == m_d, "R6", "m_tdata", m_tdata_o, m_d);
      chk(m_tlast_o == m_l, "R7", "m_tlast", m_tlast_o, m_l);
    end
    chk(blk_count_o == 16'(m_cnt), "R9", "blk_count", blk_count_o, 16'(m_cnt));
    wf = e_tready && s_tvalid_i;
    rf = e_rready && rd_valid_i;
    mf = m_v && m_tready_i;
    @(posedge clk_i);
    if (srst) begin
      m_beat = 0; m_cnt = 0; m_v = 0; m_l = 0;
    end else begin
      if (wf && m_beat == 127) begin m_cnt++; wr_lasts++; end
      if (mf && m_l) begin m_cnt++; rd_lasts++; end
      if (mf) m_v = 0;
      if (rf) begin m_v = 1; m_d = rd_data_i; m_l = (m_beat == 127); end
      if (wf || rf) m_beat = (m_beat == 127) ? 0 : m_beat + 1;
      m_cnt = m_cnt & 16'hFFFF;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R11 reset state
    chk(m_tvalid_o == 1'b0, "R11", "m_tvalid after reset", m_tvalid_o, 0);
    chk(blk_count_o == 16'd0, "R11", "blk_count after reset", blk_count_o, 0);
    // R1 address not all ones, or no command: quiet
    for (int i = 0; i < 100; i++) cycle(0, 1, i[0], 80, 80, 80, 80, 0);
    for (int i = 0; i < 40; i++)  cycle(1, 0, i[0], 80, 80, 80, 80, 0);
    // R3 R4 R5 write path, stalls on both sides
    for (int i = 0; i < 700; i++) cycle(1, 1, 1, 80, 75, 40, 50, 0);
    for (int i = 0; i < 300; i++) cycle(1, 1, 1, 100, 100, 100, 50, 0);
    chk(wr_lasts >= 3, "R4", "write blocks ended", wr_lasts, 3);
    // R10 soft reset mid-block, then realign
    cycle(1, 1, 1, 100, 100, 100, 50, 1);
    for (int i = 0; i < 200; i++) cycle(1, 1, 1, 90, 90, 60, 50, 0);
    // R6 R7 R8 read path with output backpressure
    for (int i = 0; i < 900; i++) cycle(1, 1, 0, 85, 50, 50, 60, 0);
    for (int i = 0; i < 300; i++) cycle(1, 1, 0, 100, 50, 50, 100, 0);
    cycle(1, 1, 0, 100, 50, 50, 0, 1);
    for (int i = 0; i < 600; i++) cycle(1, 1, 0, 70, 50, 50, 30, 0);
    chk(rd_lasts >= 3, "R7", "read blocks ended", rd_lasts, 3);
    // R2 switch direction with a word possibly still held
    for (int i = 0; i < 200; i++) cycle(1, 1, i[3], 80, 80, 80, 70, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule